// File: doc/BRIEF.md
# Complementary PWM Dead-Time Generator with Interrupt Qualifier

This block sits between a timer's raw PWM/compare logic and the pins and interrupt line of that timer. It takes a raw PWM level and drives two outputs: a true output that follows the level, and a complement output that follows its inverse. Whenever the level changes, the output that is turning off drops at once. The output that is turning on waits for a programmable dead time. The two outputs are therefore never active together.

The block also receives single-cycle strobes for reload, compare and input-capture events. It decides which of them raise the timer interrupt, and it records whether the most recent interrupt came from a capture. One 8-bit control register holds the settings. A simple write port writes it, and a read port always shows its current value. The register also stores a mode high bit, which the block passes to the neighbouring mode decoder.

Top module: `pwm_deadtime_irq`

## Requirements
- R1: After reset, the register reads 0x00, both outputs and the interrupt are 0, and the internal level is taken as low. The complement output therefore turns on after the dead time of the current code, counted as for a change sampled at the first clock edge.
- R2: The register layout is: bit 7 mode high, bits 6:5 interrupt select, bit 4 reserved, bits 3:1 dead-time code, bit 0 capture flag. A write with `wrEn` high takes effect at that clock edge. Bit 0 and bit 4 ignore written data. Bit 4 always reads 0.
- R3: Let n be the dead-time code and D be 0 when n is 0, otherwise 2^n clock cycles. The output that is turning on goes active D edges after the edge that samples a change of `pwmRaw`. With D equal to 0, it goes active at that same edge.
- R4: The output that is turning off is inactive from the edge that samples the change of `pwmRaw`.
- R5: If `pwmRaw` changes again before the dead time ends, the count restarts. `outTrue` and `outComp` are never both 1.
- R6: Interrupt select decodes as follows. 00 and 01: reload, compare and capture all qualify. 10: only capture qualifies. 11: only reload and compare qualify.
- R7: `timerIrq` is 1 for exactly the cycle after any cycle in which a qualifying strobe is high.
- R8: The capture flag changes only at an edge that raises the interrupt. It becomes 1 when a qualifying capture strobe was among the causes, and 0 otherwise.
- R9: `modeHigh` equals register bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read value |
| pwmRaw | input | 1 | Raw PWM level |
| reloadEvt | input | 1 | Reload event strobe |
| compareEvt | input | 1 | Compare event strobe |
| captureEvt | input | 1 | Input capture event strobe |
| outTrue | output | 1 | True PWM output |
| outComp | output | 1 | Complement PWM output |
| timerIrq | output | 1 | Interrupt pulse |
| modeHigh | output | 1 | Mode high bit for the mode decoder |

## Verification
Assertions check on every cycle that the two outputs never overlap and that a falling raw level clears the true output at once. They also check that every interrupt pulse follows an event strobe, that the capture flag holds still unless an interrupt fires, and that a capture-only interrupt leaves the flag set. The exact dead-time lengths for each code, the restart after a short glitch, and the decode of each select value against mixed strobes can only be shown by the bench's scenarios. Those scenarios compare every output with a cycle-level reference model.

// File: rtl/pwmdt_pkg.sv
package pwmdt_pkg;
  localparam int CODE_W = 3;
  localparam int CNT_W  = 1 << CODE_W;

  typedef enum logic [1:0] {
    IRQ_ALL_A = 2'b00,
    IRQ_ALL_B = 2'b01,
    IRQ_CAP   = 2'b10,
    IRQ_RC    = 2'b11
  } irqSel_e;

  typedef struct packed {
    logic [CNT_W-1:0] dwell;
  } dtCtl_t;
endpackage

// File: rtl/pwmdt_ctrl.sv
module pwmdt_ctrl
  import pwmdt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       reloadEvt,
  input  logic       compareEvt,
  input  logic       captureEvt,
  output logic [7:0] rdData,
  output logic       modeHigh,
  output logic       timerIrq,
  output dtCtl_t     dtCtl
);
  logic              modeQ;
  irqSel_e           selQ;
  logic [CODE_W-1:0] codeQ;
  logic              capFlagQ;
  logic              capQual, rcQual, fire;

  always_comb begin
    capQual = captureEvt && (selQ != IRQ_RC);
    rcQual  = (reloadEvt || compareEvt) && (selQ != IRQ_CAP);
    fire    = capQual || rcQual;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= 1'b0;
      selQ     <= IRQ_ALL_A;
      codeQ    <= '0;
      capFlagQ <= 1'b0;
      timerIrq <= 1'b0;
    end else begin
      timerIrq <= fire;
      if (fire) capFlagQ <= capQual;
      if (wrEn) begin
        modeQ <= wrData[7];
        selQ  <= irqSel_e'(wrData[6:5]);
        codeQ <= wrData[3:1];
      end
    end
  end

  always_comb begin
    dtCtl.dwell = (codeQ == '0) ? '0 : (CNT_W'(1) << codeQ);
    rdData      = {modeQ, selQ, 1'b0, codeQ, capFlagQ};
    modeHigh    = modeQ;
  end

  assert_irq_has_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    timerIrq |-> $past(reloadEvt || compareEvt || captureEvt));
  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !timerIrq |-> $stable(capFlagQ));
  assert_cap_only_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    (timerIrq && $past(selQ == IRQ_CAP)) |-> capFlagQ);
endmodule

// File: rtl/pwmdt_datapath.sv
module pwmdt_datapath
  import pwmdt_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   pwmRaw,
  input  dtCtl_t dtCtl,
  output logic   outTrue,
  output logic   outComp
);
  logic             levelQ;
  logic             waitQ;
  logic [CNT_W-1:0] cntQ;
  logic             change;
  logic             expired;

  always_comb begin
    change  = pwmRaw != levelQ;
    expired = cntQ >= dtCtl.dwell;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ  <= 1'b0;
      waitQ   <= 1'b1;
      cntQ    <= '0;
      outTrue <= 1'b0;
      outComp <= 1'b0;
    end else if (change) begin
      levelQ <= pwmRaw;
      if (dtCtl.dwell == '0) begin
        outTrue <= pwmRaw;
        outComp <= !pwmRaw;
        waitQ   <= 1'b0;
      end else begin
        outTrue <= 1'b0;
        outComp <= 1'b0;
        cntQ    <= CNT_W'(1);
        waitQ   <= 1'b1;
      end
    end else if (waitQ) begin
      if (expired) begin
        outTrue <= levelQ;
        outComp <= !levelQ;
        waitQ   <= 1'b0;
      end else begin
        cntQ <= cntQ + CNT_W'(1);
      end
    end
  end

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(outTrue && outComp));
  assert_true_drops_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(outTrue) && !$past(pwmRaw)) |-> !outTrue);
  assert_comp_drops_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(outComp) && $past(pwmRaw)) |-> !outComp);
endmodule

// File: rtl/pwm_deadtime_irq.sv
module pwm_deadtime_irq
  import pwmdt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       pwmRaw,
  input  logic       reloadEvt,
  input  logic       compareEvt,
  input  logic       captureEvt,
  output logic       outTrue,
  output logic       outComp,
  output logic       timerIrq,
  output logic       modeHigh
);
  dtCtl_t dtCtl;

  pwmdt_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .reloadEvt(reloadEvt), .compareEvt(compareEvt), .captureEvt(captureEvt),
    .rdData(rdData), .modeHigh(modeHigh), .timerIrq(timerIrq), .dtCtl(dtCtl)
  );

  pwmdt_datapath i_dp (
    .clk(clk), .rstN(rstN), .pwmRaw(pwmRaw), .dtCtl(dtCtl),
    .outTrue(outTrue), .outComp(outComp)
  );
endmodule

// File: tb/test_pwm_deadtime_irq.sv
module test_pwm_deadtime_irq;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rstN = 0, wrEn = 0, pwmRaw = 0;
  logic reloadEvt = 0, compareEvt = 0, captureEvt = 0;
  logic [7:0] wrData = 0, rdData;
  logic outTrue, outComp, timerIrq, modeHigh;
  int checks = 0, errors = 0;
  bit done = 0;

  pwm_deadtime_irq i_pwm_deadtime_irq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  bit mLevel, mWait, mT, mC, mIrq, mCap, mMode;
  bit [1:0] mSel; int mCode, mCnt;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLevel = 0; mWait = 1; mCnt = 0; mT = 0; mC = 0;
      mIrq = 0; mCap = 0; mMode = 0; mSel = 0; mCode = 0;
    end else begin
      int d; bit cq, rq;
      d = (mCode == 0) ? 0 : (1 << mCode);
      if (pwmRaw != mLevel) begin
        mLevel = pwmRaw;
        if (d == 0) begin mT = pwmRaw; mC = !pwmRaw; mWait = 0; end
        else begin mT = 0; mC = 0; mCnt = 1; mWait = 1; end
      end else if (mWait) begin
        if (mCnt >= d) begin mT = mLevel; mC = !mLevel; mWait = 0; end
        else mCnt++;
      end
      cq = captureEvt && (mSel != 2'b11);
      rq = (reloadEvt || compareEvt) && (mSel != 2'b10);
      mIrq = cq || rq;
      if (mIrq) mCap = cq;
      if (wrEn) begin mMode = wrData[7]; mSel = wrData[6:5]; mCode = wrData[3:1]; end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison at negedge
  always @(negedge clk) if (rstN && !done) begin
    chk("R3 outTrue", outTrue, mT);
    chk("R3 outComp", outComp, mC);
    chk("R7 timerIrq", timerIrq, mIrq);
    chk("R2 rdData", rdData, {mMode, mSel, 1'b0, mCode[2:0], mCap});
    chk("R9 modeHigh", modeHigh, mMode);
    chk("R5 overlap", outTrue && outComp, 0);
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    wrEn = 1; wrData = v; tick(); wrEn = 0;
  endtask

  task automatic ev(input bit r, input bit c, input bit p);
    reloadEvt = r; compareEvt = c; captureEvt = p; tick();
    reloadEvt = 0; compareEvt = 0; captureEvt = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    chk("R1 reset rdData", rdData, 0);
    chk("R1 reset irq", timerIrq, 0);
    chk("R1 reset outTrue", outTrue, 0);
    rstN = 1;
    tick(2);
    chk("R1 comp after reset code0", outComp, 1);
    // code 0 toggles
    pwmRaw = 1; tick();
    chk("R3 code0 immediate", outTrue, 1);
    chk("R4 comp off", outComp, 0);
    pwmRaw = 0; tick(3);
    // every code, both directions
    for (int c = 1; c < 8; c++) begin
      wr(8'(c << 1));
      pwmRaw = 1; tick();
      chk("R4 comp off at change", outComp, 0);
      tick((1 << c) + 2);
      chk("R3 true on after delay", outTrue, 1);
      pwmRaw = 0; tick();
      chk("R4 true off at change", outTrue, 0);
      tick((1 << c) + 2);
      chk("R3 comp on after delay", outComp, 1);
    end
    // glitch restart with code 3
    wr(8'b0000_0110);
    pwmRaw = 1; tick(5); pwmRaw = 0; tick(3); pwmRaw = 1; tick(6);
    chk("R5 restart keeps true off", outTrue, 0);
    tick(4);
    chk("R5 true on after full restart", outTrue, 1);
    // reserved and read-only bits
    wr(8'b1001_0001);
    chk("R2 bit4/bit0 ignored", rdData, 8'h80);
    chk("R9 mode high", modeHigh, 1);
    // interrupt select modes
    wr(8'b0000_0000);
    ev(0, 0, 1); chk("R8 capture sets flag", rdData[0], 1);
    ev(1, 0, 0); chk("R8 reload clears flag", rdData[0], 0);
    ev(0, 1, 1); chk("R8 mixed capture wins", rdData[0], 1);
    wr(8'b0010_0000);
    ev(0, 1, 0); chk("R6 sel01 compare fires", rdData[0], 0);
    wr(8'b0100_0000);
    ev(0, 0, 1); tick(0);
    ev(1, 1, 0); chk("R6 sel10 reload ignored, flag held", rdData[0], 1);
    wr(8'b0110_0000);
    ev(0, 0, 1); chk("R6 sel11 capture ignored", timerIrq, 0);
    chk("R8 flag held", rdData[0], 1);
    ev(1, 0, 1); chk("R8 sel11 reload clears", rdData[0], 0);
    // back-to-back strobes and event during write
    wr(8'b0000_0000);
    reloadEvt = 1; tick(3); reloadEvt = 0; tick();
    chk("R7 pulse ends", timerIrq, 0);
    wrEn = 1; wrData = 8'b0100_0000; captureEvt = 1; reloadEvt = 1; tick();
    wrEn = 0; captureEvt = 0; reloadEvt = 0;
    chk("R7 old select used", timerIrq, 1);
    // async reset mid-dead-time
    wr(8'b0000_1110); pwmRaw = 0; tick(2); pwmRaw = 1; tick(3);
    rstN = 0; tick();
    chk("R1 reset clears", rdData, 0);
    pwmRaw = 0; rstN = 1; tick(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule